// File: doc/BRIEF.md
# Grid scan timer

This block drives the grid strobes of a time-multiplexed dot-matrix fluorescent display. It divides the input clock into a base time unit T (eight clock periods by default). Every digit gets a slot of 64T, and the digits are visited in turn from the first grid up to the last enabled one, then the scan starts again at the first grid. In each slot the grid of the current digit is held high for a fraction of the slot chosen by a 3-bit brightness code. The slot then goes blank until it ends, so adjacent grids never overlap.

The block takes a 4-bit digit-count code and a 3-bit brightness code. Code 0 scans 24 digits. Any other code k scans 8+k digits, which gives 9 to 23. Brightness code d lights each grid for (8+d)/16 of its slot. Both codes are captured only where one frame ends and the next begins, so a new setting never cuts a slot short. Beside the strobes, the block outputs the index of the digit being scanned, for the segment data path, and a blank flag. It also raises a one-clock frame marker at the start of each slot of the first grid. All outputs are registered.

Top module: `grid_scan_timer`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `com` is all zero, `blank` is 1, `frame_start` is 0 and `digit_idx` is 0.
- R2: Every digit slot lasts SLOT_UNITS×TICK_DIV clocks, which is 64T with T = TICK_DIV clocks. `digit_idx` holds one value for exactly that many consecutive clocks.
- R3: In a slot with brightness code d, the first (8+d)×SLOT_UNITS/16 units are lit and the rest of the slot is blank. `blank` is 0 exactly in the lit part. With d = 7 a slot is lit for 60T and then blank for 4T.
- R4: While a slot is lit, `com` has exactly one bit set, the bit whose position equals `digit_idx` (bit 0 is the first grid). While blank, `com` is all zero.
- R5: Digit-count code 0 scans 24 digits per frame and code k (1..15) scans 8+k digits. After the last digit the scan returns to digit 0. One frame therefore lasts the digit count × SLOT_UNITS × TICK_DIV clocks.
- R6: `frame_start` is 1 for exactly one clock, the first clock of each digit-0 slot, and is 0 at all other times.
- R7: The digit-count and brightness codes are sampled only at the clock edge that ends a frame. The first frame after reset always uses code 0 (24 digits) and brightness code 0 (8/16), whatever the inputs are.
- R8: `digit_idx` equals the index of the current slot during both its lit and blank parts, and counts up by one from slot to slot.
- R9: After the first clock edge with `rst` low, the outputs show the first clock of a frame: `frame_start` is 1 and `com` bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_code | input | 4 | Digit-count code: 0 gives 24 digits, k gives 8+k |
| duty_code | input | 3 | Brightness code d: lit part is (8+d)/16 of a slot |
| com | output | 24 | One-hot grid strobes, bit 0 is the first grid |
| digit_idx | output | 5 | Index of the digit being scanned |
| blank | output | 1 | High in the unlit part of a slot and in reset |
| frame_start | output | 1 | One-clock marker at the start of the first grid's slot |

## Verification
Each output is registered one stage after the scan counters. The value seen after clock edge n therefore belongs to scan position n−1 counted from the first edge with reset low. The bench samples at the falling edge and keeps its own position counter, which starts at zero on the edge after reset is released, and it compares every clock against positions computed arithmetically. A new code is captured at the edge where the internal position wraps, and it shows in the outputs from the following `frame_start` on. For that reason the bench changes codes only early in a frame and updates its model exactly when its position counter wraps. Slot lengths and frame lengths are also measured directly as clock counts between changes of `digit_idx` and between `frame_start` pulses.

// File: rtl/gst_pkg.sv
package gst_pkg;

  typedef enum logic {
    SLOT_DARK = 1'b0,
    SLOT_LIT  = 1'b1
  } slot_phase_e;

  // Number of digits scanned for a count code; zero selects the full span.
  function automatic int digit_total(int code, int base, int top);
    int n;
    n = (code == 0) ? top : base + code;
    if (n > top) n = top;
    return n;
  endfunction

endpackage

// File: rtl/gst_prescaler.sv
module gst_prescaler #(
  parameter int TICK_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic head,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign head = (cnt_q == '0);
  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/gst_sequencer.sv
module gst_sequencer
  import gst_pkg::*;
#(
  parameter int SLOT_UNITS  = 64,
  parameter int MAX_DIGITS  = 24,
  parameter int BASE_DIGITS = 8,
  parameter int DUTY_DEN    = 16,
  parameter int DUTY_BASE   = 8,
  parameter int CODE_W      = 4,
  parameter int DUTY_W      = 3,
  parameter int DIG_W       = $clog2(MAX_DIGITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head,
  input  logic              tick,
  input  logic [CODE_W-1:0] digit_code,
  input  logic [DUTY_W-1:0] duty_code,
  output logic [DIG_W-1:0]  digit,
  output slot_phase_e       phase,
  output logic              origin
);
  localparam int UNIT_W   = $clog2(SLOT_UNITS);
  localparam int PER_STEP = SLOT_UNITS / DUTY_DEN;
  localparam logic [UNIT_W-1:0] UNIT_LAST = UNIT_W'(SLOT_UNITS - 1);

  logic [UNIT_W-1:0] unit_q;
  logic [DIG_W-1:0]  digit_q;
  logic [DIG_W-1:0]  last_q;
  logic [DUTY_W-1:0] duty_q;
  logic              slot_end, frame_end;
  logic [UNIT_W:0]   lit_units;
  logic [DIG_W-1:0]  next_last;

  assign slot_end  = tick && (unit_q == UNIT_LAST);
  assign frame_end = slot_end && (digit_q == last_q);
  assign next_last = DIG_W'(digit_total(int'(digit_code), BASE_DIGITS, MAX_DIGITS) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      unit_q  <= '0;
      digit_q <= '0;
      last_q  <= DIG_W'(MAX_DIGITS - 1);
      duty_q  <= '0;
    end else if (tick) begin
      unit_q <= slot_end ? '0 : unit_q + 1'b1;
      if (slot_end) begin
        digit_q <= frame_end ? '0 : digit_q + 1'b1;
      end
      if (frame_end) begin
        last_q <= next_last;
        duty_q <= duty_code;
      end
    end
  end

  assign lit_units = (UNIT_W+1)'((DUTY_BASE + int'(duty_q)) * PER_STEP);
  assign phase     = ({1'b0, unit_q} < lit_units) ? SLOT_LIT : SLOT_DARK;
  assign origin    = head && (unit_q == '0) && (digit_q == '0);
  assign digit     = digit_q;
endmodule

// File: rtl/gst_strobe_out.sv
module gst_strobe_out
  import gst_pkg::*;
#(
  parameter int MAX_DIGITS = 24,
  parameter int DIG_W      = $clog2(MAX_DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIG_W-1:0]      digit,
  input  slot_phase_e           phase,
  input  logic                  origin,
  output logic [MAX_DIGITS-1:0] com,
  output logic [DIG_W-1:0]      digit_idx,
  output logic                  blank,
  output logic                  frame_start
);
  for (genvar g = 0; g < MAX_DIGITS; g++) begin : g_grid
    always_ff @(posedge clk) begin
      if (rst) com[g] <= 1'b0;
      else     com[g] <= (phase == SLOT_LIT) && (digit == DIG_W'(g));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      digit_idx   <= '0;
      blank       <= 1'b1;
      frame_start <= 1'b0;
    end else begin
      digit_idx   <= digit;
      blank       <= (phase == SLOT_DARK);
      frame_start <= origin;
    end
  end
endmodule

// File: rtl/grid_scan_timer.sv
module grid_scan_timer
  import gst_pkg::*;
#(
  parameter int TICK_DIV    = 8,
  parameter int SLOT_UNITS  = 64,
  parameter int MAX_DIGITS  = 24,
  parameter int BASE_DIGITS = 8,
  parameter int DUTY_DEN    = 16,
  parameter int DUTY_BASE   = 8,
  parameter int CODE_W      = 4,
  parameter int DUTY_W      = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CODE_W-1:0]          digit_code,
  input  logic [DUTY_W-1:0]          duty_code,
  output logic [MAX_DIGITS-1:0]      com,
  output logic [$clog2(MAX_DIGITS)-1:0] digit_idx,
  output logic                       blank,
  output logic                       frame_start
);
  localparam int DIG_W = $clog2(MAX_DIGITS);

  logic             head, tick, origin;
  logic [DIG_W-1:0] digit;
  slot_phase_e      phase;

  gst_prescaler #(.TICK_DIV(TICK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .head(head),
    .tick(tick)
  );

  gst_sequencer #(
    .SLOT_UNITS (SLOT_UNITS),
    .MAX_DIGITS (MAX_DIGITS),
    .BASE_DIGITS(BASE_DIGITS),
    .DUTY_DEN   (DUTY_DEN),
    .DUTY_BASE  (DUTY_BASE),
    .CODE_W     (CODE_W),
    .DUTY_W     (DUTY_W),
    .DIG_W      (DIG_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .head      (head),
    .tick      (tick),
    .digit_code(digit_code),
    .duty_code (duty_code),
    .digit     (digit),
    .phase     (phase),
    .origin    (origin)
  );

  gst_strobe_out #(
    .MAX_DIGITS(MAX_DIGITS),
    .DIG_W     (DIG_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .digit      (digit),
    .phase      (phase),
    .origin     (origin),
    .com        (com),
    .digit_idx  (digit_idx),
    .blank      (blank),
    .frame_start(frame_start)
  );
endmodule

// File: rtl/gst_checker.sv
module gst_checker #(
  parameter int MAX_DIGITS = 24,
  parameter int DIG_W      = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic [MAX_DIGITS-1:0] com,
  input logic [DIG_W-1:0]      digit_idx,
  input logic                  blank,
  input logic                  frame_start
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (com == '0 && blank && !frame_start && digit_idx == '0)); // R1
  AST_ONE_GRID: assert property (@(posedge clk) disable iff (rst) $onehot0(com)); // R4
  AST_DARK_NO_GRID: assert property (@(posedge clk) disable iff (rst) blank |-> (com == '0)); // R4
  AST_LIT_GRID_MATCH: assert property (@(posedge clk) disable iff (rst) !blank |-> (com == (MAX_DIGITS'(1) << digit_idx))); // R4
  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (rst) frame_start |=> !frame_start); // R6
  AST_FRAME_AT_FIRST: assert property (@(posedge clk) disable iff (rst) frame_start |-> (digit_idx == '0 && !blank)); // R6
  AST_DIGIT_LIMIT: assert property (@(posedge clk) disable iff (rst) digit_idx < DIG_W'(MAX_DIGITS)); // R5
  AST_DIGIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (digit_idx != $past(digit_idx)) |-> (digit_idx == $past(digit_idx) + 1'b1 || digit_idx == '0)); // R8
endmodule

bind grid_scan_timer gst_checker #(
  .MAX_DIGITS(MAX_DIGITS),
  .DIG_W     (DIG_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .com        (com),
  .digit_idx  (digit_idx),
  .blank      (blank),
  .frame_start(frame_start)
);

// File: tb/sim_grid_scan_timer.sv
module sim_grid_scan_timer;
  localparam int TD       = 2;
  localparam int SU       = 64;
  localparam int SLOT_CLK = TD * SU;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  dcode = 4'd3;
  logic [2:0]  dty   = 3'd5;
  logic [23:0] com;
  logic [4:0]  idx;
  logic        blank, fs;

  always #2 clk = ~clk;

  grid_scan_timer #(.TICK_DIV(TD), .SLOT_UNITS(SU)) u0 (
    .clk        (clk),
    .rst        (rst),
    .digit_code (dcode),
    .duty_code  (dty),
    .com        (com),
    .digit_idx  (idx),
    .blank      (blank),
    .frame_start(fs)
  );

  int   checks = 0, fails = 0, cyc = 0;
  logic rst_seen = 1'b1;
  int   p = 0, cfg_n = 24, cfg_d = 0, fs_seen = 0, last_fs = -1, prev_len = 0, run = 0;
  logic [4:0] prev_idx = '0;
  bit   first = 1'b1, done = 1'b0;

  always @(posedge clk) begin
    rst_seen <= rst;
    cyc      <= cyc + 1;
  end

  function automatic int ndig(int k);
    return (k == 0) ? 24 : 8 + k;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (rst_seen) begin
        // R1: quiet outputs in reset
        chk(com == '0, "R1", "com", longint'(com), 0);
        chk(blank == 1'b1 && fs == 1'b0 && idx == '0, "R1", "blank/fs/idx", longint'({blank, fs, idx}), 64);
        p = 0; cfg_n = 24; cfg_d = 0; first = 1'b1; run = 0; prev_idx = '0; last_fs = -1;
      end else begin
        int          digit, u;
        bit          on;
        logic [23:0] exp_com;
        digit   = p / SLOT_CLK;
        u       = (p % SLOT_CLK) / TD;
        on      = (u < (8 + cfg_d) * (SU / 16));
        exp_com = on ? (24'(1) << digit) : 24'(0);
        if (first) begin
          chk(fs == 1'b1 && com[0] == 1'b1, "R9", "first frame_start/com0", longint'({fs, com[0]}), 3);
          first = 1'b0;
        end
        chk(com == exp_com, "R4", "com", longint'(com), longint'(exp_com));
        chk(blank == !on, "R3", "blank", longint'(blank), longint'(!on));
        chk(idx == 5'(digit), "R8", "digit_idx", longint'(idx), digit);
        chk(fs == (p == 0), "R6", "frame_start", longint'(fs), longint'(p == 0));
        if (idx != prev_idx) begin
          chk(run == SLOT_CLK, "R2", "slot length", run, SLOT_CLK);
          run = 1;
          prev_idx = idx;
        end else begin
          run++;
        end
        if (fs) begin
          if (last_fs >= 0)
            chk(cyc - last_fs == prev_len, (fs_seen == 1) ? "R7" : "R5", "frame length", cyc - last_fs, prev_len);
          last_fs = cyc;
          fs_seen++;
        end
        p++;
        if (p == cfg_n * SLOT_CLK) begin
          prev_len = p;
          p = 0;
          cfg_n = ndig(int'(dcode));
          cfg_d = int'(dty);
        end
      end
    end
  end

  task automatic wait_fs(input int n);
    int t;
    t = fs_seen + n;
    while (fs_seen < t) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R7: codes 3/5 held during reset; first frame must still be 24 digits at 8/16
    wait_fs(2);
    for (int k = 0; k < 16; k++) begin
      dcode = 4'(k);
      dty   = 3'(7 - (k % 8));   // R3: every brightness code, including 15/16
      wait_fs(2);
    end
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end
endmodule